// File: doc/BRIEF.md
# Interrupt Destination Set Resolver

This block turns an interrupt command into the set of local agents that must receive it. The command arrives as two 32-bit words. The upper word carries the 8-bit destination field. Writing the lower word carries the vector, the delivery mode, the destination mode, the level and trigger bits and a two-bit shorthand, and it starts a resolution. Each of the N agents describes itself through configuration inputs: an 8-bit physical ID, an 8-bit logical ID and a 4-bit addressing model.

One clock after each lower-word write, the block presents a registered target mask with one bit per agent, together with the decoded command fields and a one-cycle valid strobe. The strobe also fires when the mask is empty, so a requester is never left waiting. The block does not signal the agents and does not arbitrate priority between them. Lowest-priority delivery is handled by keeping only the lowest-numbered agent in the mask.

Top module: `irq_target_resolver`

## Requirements
- R1: `tgt_valid` is high for exactly the cycle after each cycle in which `cmd_lo_we` is high, and low otherwise. While it is low, every other output is zero. After reset all outputs are zero.
- R2: With the strobe, the outputs report fields of the lower word. `tgt_vector` comes from bits [7:0], `tgt_dmode` from [10:8], `tgt_logical` from [11], `tgt_level` from [14] and `tgt_trigger` from [15].
- R3: The destination is bits [31:24] of the most recently written upper word. That word is held across any number of lower-word writes. An upper-word write in the same cycle as a lower-word write is used by that resolution.
- R4: In physical mode (bit 11 = 0) with shorthand 0, destination 8'hFF selects every agent.
- R5: In physical mode with shorthand 0 and any other destination, the mask holds only the lowest-numbered agent whose physical ID equals the destination. It is all zero when no agent's ID matches.
- R6: In logical mode (bit 11 = 1) with shorthand 0, an agent whose model is 4'hF matches when the destination AND its logical ID is nonzero.
- R7: In logical mode, an agent whose model is 4'h0 matches when the destination and its logical ID have equal upper nibbles and their lower nibbles share a set bit. An agent with any other model value never matches.
- R8: Shorthand 1 (bits [19:18] = 2'b01) selects only the agent numbered `sender_idx`, whatever the destination.
- R9: Shorthand 2 (2'b10) selects every agent.
- R10: Shorthand 3 (2'b11) selects every agent except `sender_idx`.
- R11: When the delivery mode is 3'b001 (lowest priority), the mask keeps only the lowest-numbered set bit of the set resolved above.
- R12: A resolution that selects no agent still raises `tgt_valid`, with an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_we | input | 1 | Lower command word write; starts a resolution |
| cmd_lo | input | 32 | Lower command word |
| cmd_hi_we | input | 1 | Upper command word write |
| cmd_hi | input | 32 | Upper command word (destination in [31:24]) |
| sender_idx | input | $clog2(N_AGENTS) | Number of the issuing agent |
| phys_ids | input | 8*N_AGENTS | Physical ID of agent i in bits [8i+7:8i] |
| log_ids | input | 8*N_AGENTS | Logical ID of agent i in bits [8i+7:8i] |
| agent_models | input | 4*N_AGENTS | Logical model of agent i in bits [4i+3:4i] |
| tgt_valid | output | 1 | Resolution result strobe |
| tgt_mask | output | N_AGENTS | Target set, bit i for agent i |
| tgt_vector | output | 8 | Decoded vector |
| tgt_dmode | output | 3 | Decoded delivery mode |
| tgt_logical | output | 1 | Decoded destination mode |
| tgt_level | output | 1 | Decoded level bit |
| tgt_trigger | output | 1 | Decoded trigger bit |

## Verification
The only state the block holds across commands is the upper word. If that word is corrupted, it shows up at the very next lower-word write as a wrong mask, and only for shorthand 0. For that reason the bench issues lower-word writes both long after an upper-word write and in the same cycle as one. The output registers show a defect one cycle after the triggering write. The bench runs a behavioural reference model and compares every output on every clock, so a stray strobe or a mask left over after the valid cycle is caught in the cycle it appears.

// File: rtl/irqres_pkg.sv
package irqres_pkg;
   localparam int DEST_W  = 8;
   localparam int VEC_W   = 8;
   localparam int MODEL_W = 4;

   localparam logic [2:0]         DM_LOWEST   = 3'b001;
   localparam logic [MODEL_W-1:0] MODEL_FLAT  = 4'hF;
   localparam logic [MODEL_W-1:0] MODEL_CLUST = 4'h0;
   localparam logic [DEST_W-1:0]  DEST_BCAST  = 8'hFF;

   typedef enum logic [1:0] {
      SH_NONE   = 2'b00,
      SH_SELF   = 2'b01,
      SH_ALL    = 2'b10,
      SH_OTHERS = 2'b11
   } shorthand_e;

   typedef struct packed {
      logic [VEC_W-1:0] vec;
      logic [2:0]       dmode;
      logic             logical;
      logic             level;
      logic             trigger;
      shorthand_e       sh;
   } cmd_t;

   function automatic cmd_t decode_lo(input logic [31:0] w);
      cmd_t c;
      c.vec     = w[7:0];
      c.dmode   = w[10:8];
      c.logical = w[11];
      c.level   = w[14];
      c.trigger = w[15];
      c.sh      = shorthand_e'(w[19:18]);
      return c;
   endfunction
endpackage

// File: rtl/irqres_lowpick.sv
module irqres_lowpick #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] in_m,
   output logic [WIDTH-1:0] out_m
);
   assign out_m = in_m & (~in_m + WIDTH'(1));

   always_comb begin
      a_r11_pick_single: assert ($onehot0(out_m) && ((out_m & ~in_m) == '0) &&
                                 ((in_m == '0) == (out_m == '0)));
   end
endmodule

// File: rtl/irqres_match.sv
module irqres_match
   import irqres_pkg::*;
#(
   parameter int N_AGENTS = 8
) (
   input  logic [DEST_W-1:0]           dest,
   input  logic                        logical,
   input  logic [DEST_W*N_AGENTS-1:0]  phys_ids,
   input  logic [DEST_W*N_AGENTS-1:0]  log_ids,
   input  logic [MODEL_W*N_AGENTS-1:0] agent_models,
   output logic [N_AGENTS-1:0]         hit
);
   logic [N_AGENTS-1:0] phys_eq;
   logic [N_AGENTS-1:0] phys_first;
   logic [N_AGENTS-1:0] log_hit;

   for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
      logic [DEST_W-1:0]  lid;
      logic [MODEL_W-1:0] mdl;
      logic               flat_ok;
      logic               clust_ok;
      assign lid        = log_ids[g*DEST_W +: DEST_W];
      assign mdl        = agent_models[g*MODEL_W +: MODEL_W];
      assign phys_eq[g] = (phys_ids[g*DEST_W +: DEST_W] == dest);
      assign flat_ok    = |(dest & lid);
      assign clust_ok   = (dest[7:4] == lid[7:4]) && |(dest[3:0] & lid[3:0]);
      assign log_hit[g] = (mdl == MODEL_FLAT)  ? flat_ok :
                          (mdl == MODEL_CLUST) ? clust_ok : 1'b0;
   end

   irqres_lowpick #(.WIDTH(N_AGENTS)) u_phys_pick (
      .in_m  (phys_eq),
      .out_m (phys_first)
   );

   assign hit = logical              ? log_hit :
                (dest == DEST_BCAST) ? {N_AGENTS{1'b1}} : phys_first;
endmodule

// File: rtl/irq_target_resolver.sv
module irq_target_resolver
   import irqres_pkg::*;
#(
   parameter int N_AGENTS = 8,
   localparam int SIDX_W  = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_lo_we,
   input  logic [31:0]                 cmd_lo,
   input  logic                        cmd_hi_we,
   input  logic [31:0]                 cmd_hi,
   input  logic [SIDX_W-1:0]           sender_idx,
   input  logic [DEST_W*N_AGENTS-1:0]  phys_ids,
   input  logic [DEST_W*N_AGENTS-1:0]  log_ids,
   input  logic [MODEL_W*N_AGENTS-1:0] agent_models,
   output logic                        tgt_valid,
   output logic [N_AGENTS-1:0]         tgt_mask,
   output logic [VEC_W-1:0]            tgt_vector,
   output logic [2:0]                  tgt_dmode,
   output logic                        tgt_logical,
   output logic                        tgt_level,
   output logic                        tgt_trigger
);
   if (N_AGENTS < 2 || N_AGENTS > 256) begin : g_bad_n
      $error("irq_target_resolver: N_AGENTS must lie in 2..256");
   end

   logic [31:0]         hi_q;
   logic [31:0]         hi_eff;
   cmd_t                cmd;
   logic [N_AGENTS-1:0] dest_hit;
   logic [N_AGENTS-1:0] sender_oh;
   logic [N_AGENTS-1:0] sh_mask;
   logic [N_AGENTS-1:0] low_mask;
   logic [N_AGENTS-1:0] final_mask;

   assign hi_eff    = cmd_hi_we ? cmd_hi : hi_q;
   assign cmd       = decode_lo(cmd_lo);
   assign sender_oh = N_AGENTS'(1) << sender_idx;

   irqres_match #(.N_AGENTS(N_AGENTS)) u_match (
      .dest         (hi_eff[31:24]),
      .logical      (cmd.logical),
      .phys_ids     (phys_ids),
      .log_ids      (log_ids),
      .agent_models (agent_models),
      .hit          (dest_hit)
   );

   always_comb begin
      unique case (cmd.sh)
         SH_SELF:   sh_mask = sender_oh;
         SH_ALL:    sh_mask = {N_AGENTS{1'b1}};
         SH_OTHERS: sh_mask = ~sender_oh;
         default:   sh_mask = dest_hit;
      endcase
   end

   irqres_lowpick #(.WIDTH(N_AGENTS)) u_low_pick (
      .in_m  (sh_mask),
      .out_m (low_mask)
   );

   assign final_mask = (cmd.dmode == DM_LOWEST) ? low_mask : sh_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q        <= '0;
         tgt_valid   <= 1'b0;
         tgt_mask    <= '0;
         tgt_vector  <= '0;
         tgt_dmode   <= '0;
         tgt_logical <= 1'b0;
         tgt_level   <= 1'b0;
         tgt_trigger <= 1'b0;
      end else begin
         if (cmd_hi_we) hi_q <= cmd_hi;
         tgt_valid   <= cmd_lo_we;
         tgt_mask    <= cmd_lo_we ? final_mask  : '0;
         tgt_vector  <= cmd_lo_we ? cmd.vec     : '0;
         tgt_dmode   <= cmd_lo_we ? cmd.dmode   : '0;
         tgt_logical <= cmd_lo_we ? cmd.logical : 1'b0;
         tgt_level   <= cmd_lo_we ? cmd.level   : 1'b0;
         tgt_trigger <= cmd_lo_we ? cmd.trigger : 1'b0;
      end
   end

   a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_lo_we |=> tgt_valid);
   a_r1_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_lo_we |=> (!tgt_valid && tgt_mask == '0));
   a_r2_vector: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_lo_we |=> (tgt_vector == $past(cmd_lo[7:0]) && tgt_dmode == $past(cmd_lo[10:8])));
   a_r8_self_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lo_we && cmd_lo[19:18] == 2'b01) |=> tgt_mask == $past(sender_oh));
   a_r9_all: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lo_we && cmd_lo[19:18] == 2'b10 && cmd_lo[10:8] != DM_LOWEST) |=> (&tgt_mask));
   a_r10_not_self: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lo_we && cmd_lo[19:18] == 2'b11) |=> (tgt_mask & $past(sender_oh)) == '0);
   a_r11_lowest_single: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && tgt_dmode == DM_LOWEST) |-> $onehot0(tgt_mask));
endmodule

// File: tb/sim_irq_target_resolver.sv
`timescale 1ns/1ps
module sim_irq_target_resolver;
   localparam int N  = 8;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_lo_we = 1'b0, cmd_hi_we = 1'b0;
   logic [31:0]   cmd_lo = '0, cmd_hi = '0;
   logic [SW-1:0] sender_idx = '0;
   logic [8*N-1:0] phys_ids, log_ids;
   logic [4*N-1:0] agent_models;
   logic          tgt_valid, tgt_logical, tgt_level, tgt_trigger;
   logic [N-1:0]  tgt_mask;
   logic [7:0]    tgt_vector;
   logic [2:0]    tgt_dmode;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   irq_target_resolver #(.N_AGENTS(N)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_lo_we(cmd_lo_we), .cmd_lo(cmd_lo),
      .cmd_hi_we(cmd_hi_we), .cmd_hi(cmd_hi), .sender_idx(sender_idx),
      .phys_ids(phys_ids), .log_ids(log_ids), .agent_models(agent_models),
      .tgt_valid(tgt_valid), .tgt_mask(tgt_mask), .tgt_vector(tgt_vector),
      .tgt_dmode(tgt_dmode), .tgt_logical(tgt_logical), .tgt_level(tgt_level),
      .tgt_trigger(tgt_trigger));

   // Agents 0..3 flat, 4..6 cluster, 7 unknown model; agents 5 and 6 share a physical ID
   initial begin
      for (int i = 0; i < N; i++) phys_ids[8*i +: 8] = 8'h20 + 8'(i);
      phys_ids[8*6 +: 8] = 8'h25;
      log_ids = {8'hFF, 8'h44, 8'h32, 8'h31, 8'h08, 8'h04, 8'h02, 8'h01};
      agent_models = {4'h5, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};
   end

   function automatic logic [N-1:0] ref_mask(input logic [31:0] lo, input logic [7:0] d,
                                             input int snd);
      logic [N-1:0] m = '0;
      case (lo[19:18])
         2'd1: m[snd] = 1'b1;
         2'd2: m = '1;
         2'd3: begin m = '1; m[snd] = 1'b0; end
         default: begin
            if (lo[11]) begin
               for (int i = 0; i < N; i++) begin
                  logic [7:0] l = log_ids[8*i +: 8];
                  if (agent_models[4*i +: 4] == 4'hF && (d & l) != 0) m[i] = 1'b1;
                  if (agent_models[4*i +: 4] == 4'h0 && d[7:4] == l[7:4] &&
                      (d[3:0] & l[3:0]) != 0) m[i] = 1'b1;
               end
            end else if (d == 8'hFF) m = '1;
            else begin
               for (int i = N - 1; i >= 0; i--)
                  if (phys_ids[8*i +: 8] == d) begin m = '0; m[i] = 1'b1; end
            end
         end
      endcase
      if (lo[10:8] == 3'b001) begin
         logic [N-1:0] r = '0;
         for (int i = N - 1; i >= 0; i--) if (m[i]) begin r = '0; r[i] = 1'b1; end
         m = r;
      end
      return m;
   endfunction

   // Reference model
   logic [31:0] m_hi = '0;
   logic        e_valid = 0, e_logical = 0, e_level = 0, e_trigger = 0;
   logic [N-1:0] e_mask = '0;
   logic [7:0]  e_vec = '0;
   logic [2:0]  e_dmode = '0;
   string       e_req = "R1";

   always @(posedge clk) begin
      logic [31:0] h;
      h = cmd_hi_we ? cmd_hi : m_hi;
      if (!rst_n) begin
         m_hi <= '0; e_valid <= 0; e_mask <= '0; e_vec <= '0; e_dmode <= '0;
         e_logical <= 0; e_level <= 0; e_trigger <= 0; e_req <= "R1";
      end else begin
         if (cmd_hi_we) m_hi <= cmd_hi;
         e_valid   <= cmd_lo_we;
         e_mask    <= cmd_lo_we ? ref_mask(cmd_lo, h[31:24], int'(sender_idx)) : '0;
         e_vec     <= cmd_lo_we ? cmd_lo[7:0] : '0;
         e_dmode   <= cmd_lo_we ? cmd_lo[10:8] : '0;
         e_logical <= cmd_lo_we & cmd_lo[11];
         e_level   <= cmd_lo_we & cmd_lo[14];
         e_trigger <= cmd_lo_we & cmd_lo[15];
         e_req     <= cmd_lo_we ? cur_req : "R1";
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (tgt_valid !== e_valid) begin
            errors++;
            $display("FAIL R1 valid: got %0b expected %0b", tgt_valid, e_valid);
         end
         if (tgt_mask !== e_mask) begin
            errors++;
            $display("FAIL %s mask: got %b expected %b", e_req, tgt_mask, e_mask);
         end
         if ({tgt_vector, tgt_dmode, tgt_logical, tgt_level, tgt_trigger} !==
             {e_vec, e_dmode, e_logical, e_level, e_trigger}) begin
            errors++;
            $display("FAIL R2 fields: got %h/%0d/%b%b%b expected %h/%0d/%b%b%b",
                     tgt_vector, tgt_dmode, tgt_logical, tgt_level, tgt_trigger,
                     e_vec, e_dmode, e_logical, e_level, e_trigger);
         end
      end
   end

   task automatic set_hi(input logic [7:0] d);
      @(negedge clk);
      cmd_hi_we = 1; cmd_hi = {d, 24'h0};
      @(negedge clk);
      cmd_hi_we = 0;
   endtask

   task automatic send(input string req, input logic [31:0] lo, input int snd);
      @(negedge clk);
      cur_req = req; cmd_lo_we = 1; cmd_lo = lo; sender_idx = SW'(snd);
      @(negedge clk);
      cmd_lo_we = 0; cmd_lo = '0;
   endtask

   task automatic send_both(input string req, input logic [31:0] lo, input logic [7:0] d);
      @(negedge clk);
      cur_req = req; cmd_lo_we = 1; cmd_lo = lo; cmd_hi_we = 1; cmd_hi = {d, 24'h0};
      @(negedge clk);
      cmd_lo_we = 0; cmd_hi_we = 0; cmd_lo = '0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      checks++;   // R1 reset state
      if (tgt_valid !== 0 || tgt_mask !== '0) begin
         errors++;
         $display("FAIL R1 reset: got %0b/%b expected 0/0", tgt_valid, tgt_mask);
      end
      @(negedge clk); rst_n = 1;
      set_hi(8'hFF);
      send("R4", 32'h0000_C041, 0);        // R2 fields with level and trigger set
      send("R3", 32'h0000_0042, 0);        // R3 destination retained
      set_hi(8'h23);
      send("R5", 32'h0000_0050, 0);        // R5 single physical match
      set_hi(8'h25);
      send("R5", 32'h0000_0051, 0);        // R5 duplicated ID, lowest wins
      set_hi(8'h99);
      send("R12", 32'h0000_0052, 0);       // R12 empty mask still strobed
      set_hi(8'h05);
      send("R6", 32'h0000_0860, 0);        // R6 flat logical
      set_hi(8'h33);
      send("R7", 32'h0000_0861, 0);        // R7 cluster and flat mix
      set_hi(8'h44);
      send("R7", 32'h0000_0862, 0);        // R7 cluster single
      set_hi(8'hF8);
      send("R7", 32'h0000_0863, 0);        // R7 unknown model never matches
      send("R8", 32'h0004_0070, 5);        // R8 self
      send("R9", 32'h0008_0071, 2);        // R9 all
      send("R10", 32'h000C_0072, 3);       // R10 all but sender
      send("R10", 32'h000C_0073, 0);       // R10 sender 0
      send("R11", 32'h000C_0174, 0);       // R11 lowest of others
      set_hi(8'h33);
      send("R11", 32'h0000_0975, 0);       // R11 lowest of logical set
      send_both("R3", 32'h0000_0076, 8'h27);   // R3 same-cycle upper word
      send_both("R11", 32'h0000_0177, 8'h77);  // R11 on empty set, R12
      send("R1", 32'h0000_0078, 0);        // R1 back-to-back strobes
      send("R1", 32'h0000_0079, 0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule